// File: doc/BRIEF.md
# Video capture control and interrupt register bank

This block is the software-facing register bank of a video capture front end. A host reaches it through a small word-addressed bus: one write strobe with address and data, and a read data port that always shows the word at the current address in the same cycle. Through it the host arms capture, picks which interrupts reach the shared interrupt line, and clears latched events and error flags by writing ones to them.

Capture is armed with a start bit, but the enable that goes to the datapath only moves on a frame boundary pulse. Setting or clearing the start bit therefore takes effect on the next frame boundary, so output never begins or ends part way through a picture. Event pulses from the capture path (frame boundary, status change, end of field, FIFO overflow, picture drop) are latched here. Measured values (FIFO level, samples and lines per picture, and lock, stability, scan and resolution flags) are produced elsewhere and only shown through the read port.

Top module: `vcap_csr`

## Requirements
- R1: After an asynchronous active-low reset, `run_o` and `irq_o` are 0 and the control, status and interrupt words read their input-mirrored bits only, with every stored bit 0.
- R2: Address 0 is the control word. Bit 0 is the start bit, bit 1 enables the status-change interrupt, bit 2 enables the end-of-field interrupt. All three read back as written and every other bit reads 0.
- R3: `run_o` changes only on a cycle with `frame_start_i` high. It then takes the start bit value held before that edge. Status bit 0 always equals `run_o`.
- R4: Address 2 is the interrupt word. Bit 1 latches `status_evt_i` and bit 2 latches `eof_evt_i`, whatever the enables are. Each stays set until a write to address 2 with a 1 in that bit position.
- R5: `irq_o` is 1 exactly when an interrupt word bit and its matching control enable are both 1.
- R6: Status bit 9 is set by `fifo_ovf_i` and stays set until a write to address 1 with bit 9 set.
- R7: Status bit 14 is set by `pic_drop_i`. Status bits 21:15 count drop pulses, hold at 127 instead of wrapping, and clear together with bit 14 when address 1 is written with bit 14 set.
- R8: If an event pulse and a write-one clear of its bit land in the same cycle, the bit ends up set. For a picture drop the count then reads 1.
- R9: Status bits 6:1, 13:12 and 31:22 read 0. Bits 7, 8, 10 and 11 show `interlaced_i`, `stable_i`, `res_valid_i` and `locked_i` as they are in that cycle.
- R10: Addresses 3, 4 and 5 return `fifo_level_i`, `sample_cnt_i` and `line_cnt_i`, zero-extended. Every other unused address reads 0.
- R11: Writes to addresses 3 and up, and to bits with no stored state, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Word address for read and write |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| frame_start_i | input | 1 | Frame boundary pulse |
| status_evt_i | input | 1 | Status change event pulse |
| eof_evt_i | input | 1 | End of field or frame pulse |
| fifo_ovf_i | input | 1 | Input FIFO overflow pulse |
| pic_drop_i | input | 1 | Picture dropped pulse |
| interlaced_i | input | 1 | Interlaced scan detected |
| stable_i | input | 1 | Line length stable |
| res_valid_i | input | 1 | Measured resolution valid |
| locked_i | input | 1 | Receiver lock |
| fifo_level_i | input | 12 | FIFO fill level |
| sample_cnt_i | input | 16 | Active samples per line |
| line_cnt_i | input | 16 | Active lines per field |
| run_o | output | 1 | Capture output enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Every stored result is due one clock after its cause. A write, an event pulse or a frame boundary seen at a rising edge shows on `run_o`, `irq_o` and the read word at the next sample point, while mirrored inputs and the address select show in the cycle they are driven. The bench drives inputs just after the falling edge and compares all three outputs with a behavioural model 1 ns later, every cycle. The model is updated on the same rising edge as the design, so each comparison sees exactly one edge of updates. Same-cycle event and clear collisions, saturation of the drop count, and writes to read-only words get their own directed checks.

// File: rtl/vcap_csr_pkg.sv
package vcap_csr_pkg;
  localparam int unsigned A_CTRL  = 0;
  localparam int unsigned A_STAT  = 1;
  localparam int unsigned A_IRQ   = 2;
  localparam int unsigned A_LEVEL = 3;
  localparam int unsigned A_SAMP  = 4;
  localparam int unsigned A_LINE  = 5;

  localparam int unsigned C_GO     = 0;
  localparam int unsigned C_IE_SU  = 1;
  localparam int unsigned C_IE_EOF = 2;

  localparam int unsigned S_RUN    = 0;
  localparam int unsigned S_INTL   = 7;
  localparam int unsigned S_STABLE = 8;
  localparam int unsigned S_OVF    = 9;
  localparam int unsigned S_RES    = 10;
  localparam int unsigned S_LOCK   = 11;
  localparam int unsigned S_DROP   = 14;
  localparam int unsigned S_DCNT   = 15;

  localparam int unsigned I_SU  = 1;
  localparam int unsigned I_EOF = 2;
  localparam int unsigned N_IRQ = 2;

  typedef struct packed {
    logic ie_eof;
    logic ie_su;
    logic go;
  } ctrl_t;
endpackage

// File: rtl/vcap_w1c_bit.sv
module vcap_w1c_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  assert_w1c_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/vcap_run_gate.sv
module vcap_run_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_start_i,
  input  logic go_i,
  output logic run_o
);
  // Output enable follows the start bit only on frame boundaries
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            run_o <= 1'b0;
    else if (frame_start_i) run_o <= go_i;
  end

  assert_run_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(run_o));
  assert_run_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (run_o == $past(go_i)));
endmodule

// File: rtl/vcap_drop_track.sv
module vcap_drop_track #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             drop_i,
  input  logic             clr_i,
  output logic             flag_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_base;
  assign cnt_base = clr_i ? '0 : cnt_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      cnt_o  <= '0;
    end else if (drop_i) begin
      flag_o <= 1'b1;
      if (cnt_base != CNT_MAX) cnt_o <= cnt_base + CNT_ONE;
    end else if (clr_i) begin
      flag_o <= 1'b0;
      cnt_o  <= '0;
    end
  end

  assert_drop_sat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_i && !clr_i && cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX));
  assert_drop_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o != '0) |-> flag_o);
  assert_drop_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !drop_i) |=> (cnt_o == '0 && !flag_o));
  assert_drop_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && drop_i) |=> (cnt_o == CNT_ONE && flag_o));
endmodule

// File: rtl/vcap_csr.sv
module vcap_csr
  import vcap_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LVL_W  = 12,
  parameter int unsigned MEAS_W = 16,
  parameter int unsigned DROP_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              frame_start_i,
  input  logic              status_evt_i,
  input  logic              eof_evt_i,
  input  logic              fifo_ovf_i,
  input  logic              pic_drop_i,
  input  logic              interlaced_i,
  input  logic              stable_i,
  input  logic              res_valid_i,
  input  logic              locked_i,
  input  logic [LVL_W-1:0]  fifo_level_i,
  input  logic [MEAS_W-1:0] sample_cnt_i,
  input  logic [MEAS_W-1:0] line_cnt_i,
  output logic              run_o,
  output logic              irq_o
);
  localparam int unsigned DCNT_HI = S_DCNT + DROP_W - 1;

  logic wr_ctrl, wr_stat, wr_irq;
  assign wr_ctrl = wr_en_i && (addr_i == ADDR_W'(A_CTRL));
  assign wr_stat = wr_en_i && (addr_i == ADDR_W'(A_STAT));
  assign wr_irq  = wr_en_i && (addr_i == ADDR_W'(A_IRQ));

  ctrl_t ctrl_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_ctrl) begin
      ctrl_q.go     <= wdata_i[C_GO];
      ctrl_q.ie_su  <= wdata_i[C_IE_SU];
      ctrl_q.ie_eof <= wdata_i[C_IE_EOF];
    end
  end

  vcap_run_gate u_gate (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .go_i          (ctrl_q.go),
    .run_o         (run_o)
  );

  logic [N_IRQ-1:0] irq_evt, irq_en, irq_sts;
  assign irq_evt = {eof_evt_i, status_evt_i};
  assign irq_en  = {ctrl_q.ie_eof, ctrl_q.ie_su};

  for (genvar g = 0; g < N_IRQ; g++) begin : g_irq
    vcap_w1c_bit u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (irq_evt[g]),
      .clr_i  (wr_irq && wdata_i[I_SU + g]),
      .q_o    (irq_sts[g])
    );
  end

  assign irq_o = |(irq_sts & irq_en);

  logic ovf_q;
  vcap_w1c_bit u_ovf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (fifo_ovf_i),
    .clr_i  (wr_stat && wdata_i[S_OVF]),
    .q_o    (ovf_q)
  );

  logic              drop_q;
  logic [DROP_W-1:0] drop_cnt;
  vcap_drop_track #(.CNT_W(DROP_W)) u_drop (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .drop_i (pic_drop_i),
    .clr_i  (wr_stat && wdata_i[S_DROP]),
    .flag_o (drop_q),
    .cnt_o  (drop_cnt)
  );

  logic [DATA_W-1:0] stat_w, ctrl_w, irq_w;
  always_comb begin
    ctrl_w = '0;
    ctrl_w[C_GO]     = ctrl_q.go;
    ctrl_w[C_IE_SU]  = ctrl_q.ie_su;
    ctrl_w[C_IE_EOF] = ctrl_q.ie_eof;

    stat_w = '0;
    stat_w[S_RUN]    = run_o;
    stat_w[S_INTL]   = interlaced_i;
    stat_w[S_STABLE] = stable_i;
    stat_w[S_OVF]    = ovf_q;
    stat_w[S_RES]    = res_valid_i;
    stat_w[S_LOCK]   = locked_i;
    stat_w[S_DROP]   = drop_q;
    stat_w[DCNT_HI:S_DCNT] = drop_cnt;

    irq_w = '0;
    irq_w[I_EOF:I_SU] = irq_sts;
  end

  always_comb begin
    case (addr_i)
      ADDR_W'(A_CTRL):  rdata_o = ctrl_w;
      ADDR_W'(A_STAT):  rdata_o = stat_w;
      ADDR_W'(A_IRQ):   rdata_o = irq_w;
      ADDR_W'(A_LEVEL): rdata_o = DATA_W'(fifo_level_i);
      ADDR_W'(A_SAMP):  rdata_o = DATA_W'(sample_cnt_i);
      ADDR_W'(A_LINE):  rdata_o = DATA_W'(line_cnt_i);
      default:          rdata_o = '0;
    endcase
  end

  assert_irq_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.ie_su && !ctrl_q.ie_eof) |-> !irq_o);
  assert_run_mirror_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(A_STAT)) |-> (rdata_o[S_RUN] == run_o));
endmodule

// File: tb/tb_vcap_csr.sv
`timescale 1ns/100ps
module tb_vcap_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fs = 0, su = 0, eof = 0, ovf = 0, pd = 0;
  logic        intl = 0, stab = 0, resv = 0, lock = 0;
  logic [11:0] lvl = '0;
  logic [15:0] samp = '0, line = '0;
  logic        run, irq;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vcap_csr dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .frame_start_i(fs),
    .status_evt_i(su), .eof_evt_i(eof), .fifo_ovf_i(ovf), .pic_drop_i(pd),
    .interlaced_i(intl), .stable_i(stab), .res_valid_i(resv),
    .locked_i(lock), .fifo_level_i(lvl), .sample_cnt_i(samp),
    .line_cnt_i(line), .run_o(run), .irq_o(irq)
  );

  // behavioural reference
  int m_go, m_ies, m_iee, m_run, m_isu, m_ieof, m_ovf, m_drop, m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_go = 0; m_ies = 0; m_iee = 0; m_run = 0; m_isu = 0;
      m_ieof = 0; m_ovf = 0; m_drop = 0; m_cnt = 0;
    end else begin
      bit clr_drop;
      if (fs) m_run = m_go;
      if (wr_en && addr == 0) begin
        m_go = wdata[0]; m_ies = wdata[1]; m_iee = wdata[2];
      end
      if (su) m_isu = 1; else if (wr_en && addr == 2 && wdata[1]) m_isu = 0;
      if (eof) m_ieof = 1; else if (wr_en && addr == 2 && wdata[2]) m_ieof = 0;
      if (ovf) m_ovf = 1; else if (wr_en && addr == 1 && wdata[9]) m_ovf = 0;
      clr_drop = wr_en && addr == 1 && wdata[14];
      if (pd) begin
        m_drop = 1;
        m_cnt = clr_drop ? 1 : (m_cnt < 127 ? m_cnt + 1 : 127);
      end else if (clr_drop) begin
        m_drop = 0; m_cnt = 0;
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    logic [31:0] v = '0;
    case (a)
      0: v = {29'd0, m_iee[0], m_ies[0], m_go[0]};
      1: begin
        v[0] = m_run[0]; v[7] = intl; v[8] = stab; v[9] = m_ovf[0];
        v[10] = resv; v[11] = lock; v[14] = m_drop[0]; v[21:15] = m_cnt[6:0];
      end
      2: begin v[1] = m_isu[0]; v[2] = m_ieof[0]; end
      3: v = {20'd0, lvl};
      4: v = {16'd0, samp};
      5: v = {16'd0, line};
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic string rd_tag(input logic [3:0] a);
    case (a)
      0: return "R2";
      1: return "R9";
      2: return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison 1 ns after the falling edge
  always @(negedge clk) begin
    #1;
    if (!done) begin
      check("R3 run_o", {31'd0, run}, m_run);
      check("R5 irq_o", {31'd0, irq}, ((m_isu & m_ies) | (m_ieof & m_iee)));
      check(rd_tag(addr), rdata, exp_rd(addr));
    end
  end

  task automatic idle();
    @(negedge clk);
    wr_en = 0; fs = 0; su = 0; eof = 0; ovf = 0; pd = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d; fs = 0; su = 0; eof = 0; ovf = 0; pd = 0;
  endtask

  task automatic peek(input logic [3:0] a);
    @(negedge clk);
    wr_en = 0; addr = a; fs = 0; su = 0; eof = 0; ovf = 0; pd = 0;
    #1.2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    peek(0); check("R1 ctrl", rdata, 32'h0);
    check("R1 run_o", {31'd0, run}, 32'h0);
    check("R1 irq_o", {31'd0, irq}, 32'h0);
    rst_n = 1;
    peek(1); check("R1 status", rdata, 32'h0);
    peek(2); check("R1 irq word", rdata, 32'h0);

    // R2 readback, R3 gating
    wr(0, 32'hFFFF_FFFF);
    peek(0); check("R2 ctrl readback", rdata, 32'h7);
    peek(1); check("R3 no run before boundary", {31'd0, run}, 32'h0);
    @(negedge clk); fs = 1; addr = 1;
    peek(1); check("R3 run after boundary", rdata & 32'h1, 32'h1);
    wr(0, 32'h6);
    peek(1); check("R3 run held until boundary", {31'd0, run}, 32'h1);
    @(negedge clk); fs = 1;
    peek(1); check("R3 run stops at boundary", {31'd0, run}, 32'h0);

    // R4 / R5: latch without enable, then enable
    wr(0, 32'h0);
    @(negedge clk); su = 1;
    peek(2); check("R4 latch w/o enable", rdata, 32'h2);
    check("R5 masked irq", {31'd0, irq}, 32'h0);
    wr(0, 32'h2);
    peek(2); check("R5 irq enabled", {31'd0, irq}, 32'h1);
    wr(2, 32'h2);
    peek(2); check("R4 w1c", rdata, 32'h0);
    check("R5 irq drops", {31'd0, irq}, 32'h0);

    // R6 overflow sticky
    @(negedge clk); ovf = 1;
    peek(1); check("R6 ovf set", rdata & 32'h200, 32'h200);
    wr(1, 32'h0);
    peek(1); check("R6 write 0 keeps", rdata & 32'h200, 32'h200);
    wr(1, 32'h200);
    peek(1); check("R6 cleared", rdata & 32'h200, 32'h0);

    // R7 drop count saturation
    for (int i = 0; i < 140; i++) begin @(negedge clk); pd = 1; end
    peek(1); check("R7 saturated", rdata[21:14], {7'd127, 1'b1});
    wr(1, 32'h4000);
    peek(1); check("R7 cleared", rdata[21:14], 8'h0);

    // R8 collision
    for (int i = 0; i < 3; i++) begin @(negedge clk); pd = 1; end
    @(negedge clk); wr_en = 1; addr = 1; wdata = 32'h4200; pd = 1; ovf = 1;
    peek(1); check("R8 drop wins", rdata[21:14], {7'd1, 1'b1});
    check("R8 ovf wins", rdata & 32'h200, 32'h200);
    @(negedge clk); wr_en = 1; addr = 2; wdata = 32'h4; eof = 1;
    peek(2); check("R8 eof wins", rdata, 32'h4);

    // R9 / R10 / R11
    @(negedge clk); intl = 1; stab = 1; resv = 0; lock = 1; lvl = 12'hABC;
    samp = 16'h1234; line = 16'h0438; wr_en = 0; addr = 1;
    #1.2; check("R9 mirrors", rdata & 32'h0000_3FFE, 32'h0000_0B80);
    wr(3, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF); wr(15, 32'hFFFF_FFFF);
    peek(3); check("R11 level untouched", rdata, 32'h0000_0ABC);
    peek(4); check("R10 samples", rdata, 32'h0000_1234);
    peek(5); check("R10 lines", rdata, 32'h0000_0438);
    peek(9); check("R10 unused addr", rdata, 32'h0);
    peek(0); check("R11 ctrl untouched", rdata, 32'h2);

    // random traffic, compared every cycle by the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      fs    = ($urandom % 12) == 0;
      su    = ($urandom % 9) == 0;
      eof   = ($urandom % 9) == 0;
      ovf   = ($urandom % 25) == 0;
      pd    = ($urandom % 4) == 0;
      intl  = $urandom; stab = $urandom; resv = $urandom; lock = $urandom;
      lvl   = 12'($urandom); samp = 16'($urandom); line = 16'($urandom);
      addr  = 4'($urandom % 8);
      wr_en = ($urandom % 6) == 0;
      wdata = ($urandom % 3 == 0) ? 32'($urandom) : 32'($urandom) & 32'h0000_01FF;
    end
    idle();
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule